// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the bus-side engine of a 2048-byte serial EEPROM on a two-wire I2C bus. It runs from a fast system clock and oversamples the bus clock and data lines. From those samples it finds bus START and STOP conditions, decodes a one-byte device selector, and moves bytes between the bus and an on-chip register array. The array has eleven-bit addresses.

A host writes one byte with this sequence: selector, low address byte, data byte, STOP. That STOP starts an internal programming interval of a set number of system clocks. During that interval the block does not acknowledge its selector, so a host can poll until the part is ready. Reads come in three forms:

- A current-address read uses the internal pointer.
- A random read first sets the pointer with a write that carries no data, then issues a repeated START and a read.
- A sequential read continues for as long as the host acknowledges each byte.

A write-protect input lets the address phase complete and then refuses the data.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block changes its SDA pull-down (`sda_oe_o`, 1 = pull low) only while SCL is low. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP.
- R2: The selector byte is {device code (bits 7:4, default 4'b1010), address bits 10:8 (bits 3:1), direction (bit 0, 1 = read)}. The block acknowledges it only on a code match while idle. A selector with any other code gets no acknowledge.
- R3: A STOP that ends an accepted data byte starts a busy interval of `WR_CYCLES` system clocks. During that interval the selector is not acknowledged. Once the interval ends, a selector with direction 0 is acknowledged.
- R4: A byte write stores the data byte at the address formed by selector bits 3:1 and the second byte. The block acknowledges the selector, the address byte and the data byte.
- R5: A random read returns the byte stored at the address set by the preceding data-less write.
- R6: The address pointer holds the last accessed address plus one. A current-address read that follows a write or a read of address N returns the byte at N+1.
- R7: In a sequential read, each host acknowledge makes the block advance the pointer and send the next byte. The pointer wraps from 2047 to 0.
- R8: Read data is sent most significant bit first. A host not-acknowledge ends the read, and the block releases SDA for the following STOP.
- R9: With `wp_i` high, the selector and address bytes are still acknowledged. The first data byte gets no acknowledge, the memory keeps its contents, and no busy interval starts.
- R10: After reset, SDA is released and the block is not busy, so a selector is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp_i | input | 1 | Write protect, 1 blocks programming |
| sda_oe_o | output | 1 | Pull-down enable for SDA, 1 drives the line low |

## Verification
On every cycle, the checker confirms four things. The SDA pull-down moves only while SCL is low. The busy window lasts exactly the configured number of clocks after a programming start. No selector acknowledge begins while busy. No data acknowledge begins while write protect is high. It also confirms that SDA is released during the host's acknowledge slot in a read. The bench scenarios are the only way to show the stored contents: which address a write lands on, the pointer value seen by current-address reads, the wrap from 2047 to 0 in a sequential read, and the bit order of the returned bytes. They are also the only way to show that a polling host sees not-acknowledge first and acknowledge later.

// File: rtl/eep_pkg.sv
package eep_pkg;
  // Protocol engine phases
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DEV  = 3'd1,  // receiving selector byte
    S_ALO  = 3'd2,  // receiving low address byte
    S_WDAT = 3'd3,  // receiving data byte
    S_SACK = 3'd4,  // slave acknowledge slot
    S_RDAT = 3'd5,  // shifting read data out
    S_MACK = 3'd6,  // host acknowledge slot
    S_IGN  = 3'd7   // ignore until START/STOP
  } state_t;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_prev <= scl_sync[1];
      sda_prev <= sda_sync[1];
    end
  end

  assign scl_s    = scl_sync[1];
  assign sda_s    = sda_sync[1];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         WR_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  import eep_pkg::*;

  localparam int AW = 11;
  localparam int HW = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, wr_start;
  logic [7:0] rd_data;

  state_t        state_q, state_d, after_q, after_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    rxsh_q, rxsh_d, txsh_q, txsh_d;
  logic          drv_q, drv_d, mack_q, mack_d, wr_pend_q, wr_pend_d;
  logic [AW-1:0] addr_q, addr_d, wr_addr_q, wr_addr_d;
  logic [HW-1:0] hi_q, hi_d;
  logic [7:0]    wr_data_q, wr_data_d;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy)
  );

  eep_mem_array #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(wr_start), .waddr(wr_addr_q), .wdata(wr_data_q),
    .raddr(addr_q), .rdata(rd_data)
  );

  always_comb begin
    state_d   = state_q;
    after_d   = after_q;
    bitcnt_d  = bitcnt_q;
    rxsh_d    = rxsh_q;
    txsh_d    = txsh_q;
    drv_d     = drv_q;
    mack_d    = mack_q;
    wr_pend_d = wr_pend_q;
    addr_d    = addr_q;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    hi_d      = hi_q;
    wr_start  = 1'b0;

    if (start_ev) begin
      state_d  = S_DEV;
      bitcnt_d = '0;
      drv_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = S_IDLE;
      drv_d   = 1'b0;
      if (wr_pend_q) begin
        wr_start  = 1'b1;
        wr_pend_d = 1'b0;
      end
    end else begin
      unique case (state_q)
        S_DEV, S_ALO, S_WDAT: begin
          if (scl_rise && bitcnt_q < 4'd8) begin
            rxsh_d   = {rxsh_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            bitcnt_d = '0;
            if (state_q == S_DEV) begin
              if (rxsh_q[7:4] == DEV_CODE && !busy) begin
                drv_d   = 1'b1;
                state_d = S_SACK;
                hi_d    = rxsh_q[HW:1];
                after_d = rxsh_q[0] ? S_RDAT : S_ALO;
              end else begin
                state_d = S_IGN;
              end
            end else if (state_q == S_ALO) begin
              drv_d   = 1'b1;
              state_d = S_SACK;
              addr_d  = {hi_q, rxsh_q};
              after_d = S_WDAT;
            end else begin
              if (wp_i) begin
                state_d = S_IGN;
              end else begin
                drv_d     = 1'b1;
                state_d   = S_SACK;
                wr_addr_d = addr_q;
                wr_data_d = rxsh_q;
                wr_pend_d = 1'b1;
                addr_d    = addr_q + 1'b1;
                after_d   = S_IGN;
              end
            end
          end
        end
        S_SACK: begin
          if (scl_fall) begin
            drv_d    = 1'b0;
            state_d  = after_q;
            bitcnt_d = '0;
            if (after_q == S_RDAT) begin
              txsh_d   = rd_data;
              drv_d    = ~rd_data[7];
              addr_d   = addr_q + 1'b1;
              bitcnt_d = 4'd1;
            end
          end
        end
        S_RDAT: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              drv_d   = 1'b0;
              state_d = S_MACK;
            end else begin
              txsh_d   = {txsh_q[6:0], 1'b0};
              drv_d    = ~txsh_q[6];
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state_d  = S_RDAT;
              txsh_d   = rd_data;
              drv_d    = ~rd_data[7];
              addr_d   = addr_q + 1'b1;
              bitcnt_d = 4'd1;
            end else begin
              state_d = S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      after_q   <= S_IDLE;
      bitcnt_q  <= '0;
      rxsh_q    <= '0;
      txsh_q    <= '0;
      drv_q     <= 1'b0;
      mack_q    <= 1'b0;
      wr_pend_q <= 1'b0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      hi_q      <= '0;
    end else begin
      state_q   <= state_d;
      after_q   <= after_d;
      bitcnt_q  <= bitcnt_d;
      rxsh_q    <= rxsh_d;
      txsh_q    <= txsh_d;
      drv_q     <= drv_d;
      mack_q    <= mack_d;
      wr_pend_q <= wr_pend_d;
      addr_q    <= addr_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      hi_q      <= hi_d;
    end
  end

  assign sda_oe_o = drv_q;
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int WR_CYCLES = 10000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            wp_i,
  input logic            sda_oe_o,
  input logic            busy,
  input logic            wr_start,
  input eep_pkg::state_t state
);
  import eep_pkg::*;

  localparam int SW = $clog2(WR_CYCLES + 3);
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_q <= '0;
    else if (wr_start)                  since_q <= SW'(1);
    else if (since_q != SW'(WR_CYCLES + 2)) since_q <= since_q + 1'b1;
  end

  // R1
  sda_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R3
  busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> since_q == SW'(WR_CYCLES + 1));

  // R2
  no_sel_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_o) && $past(state) == S_DEV) |-> !$past(busy));

  // R9
  no_data_ack_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_o) && $past(state) == S_WDAT) |-> !$past(wp_i));

  // R8
  host_ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK) |-> !sda_oe_o);
endmodule

bind i2c_eeprom_slave eep_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i),
  .sda_oe_o(sda_oe_o), .busy(busy), .wr_start(wr_start), .state(state_q)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int WRC = 300;

  logic clk, rst_n, scl, sda_m, wp, sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int exp_q[$];
  int act_q[$];
  string req_q[$];
  bit done = 0;

  i2c_eeprom_slave #(.DEV_CODE(4'b1010), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .sda_oe_o(sda_oe)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // Monitor: pops expected/observed pairs and compares them
  initial begin
    forever begin
      wait (act_q.size() > 0 && exp_q.size() > 0);
      begin
        int e, a;
        string r;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (a != e) begin
          errors++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", r, a, e);
        end
      end
    end
  end

  task automatic expect_item(string r, int e);
    req_q.push_back(r);
    exp_q.push_back(e);
  endtask

  task automatic observe(int a);
    act_q.push_back(a);
  endtask

  task automatic hp;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1; hp; scl = 1; hp; sda_m = 0; hp; scl = 0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 0; hp; scl = 1; hp; sda_m = 1; hp;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hp; scl = 1; hp; scl = 0; hp;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; hp; scl = 1; hp; b = sda_line; hp; scl = 0; hp;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~host_ack);
  endtask

  function automatic logic [7:0] sel(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic wait_ready;
    logic ack;
    for (int i = 0; i < 40; i++) begin
      bus_start; send_byte(sel(11'd0, 1'b0), ack); bus_stop;
      if (ack) break;
    end
  endtask

  task automatic byte_write(input logic [10:0] a, input logic [7:0] d, input string r);
    logic ack;
    bus_start;
    expect_item({r, " selector ack"}, 1); send_byte(sel(a, 1'b0), ack); observe(ack);
    expect_item({r, " address ack"}, 1);  send_byte(a[7:0], ack);        observe(ack);
    expect_item({r, " data ack"}, 1);     send_byte(d, ack);             observe(ack);
    bus_stop;
  endtask

  task automatic set_pointer(input logic [10:0] a);
    logic ack;
    bus_start;
    send_byte(sel(a, 1'b0), ack);
    send_byte(a[7:0], ack);
  endtask

  task automatic read_seq(input int n, input int e0, input int e1, input int e2,
                          input string r, input logic use_rs);
    logic ack;
    logic [7:0] v;
    int ev[3];
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    bus_start;
    send_byte(sel(11'd0, 1'b1), ack);
    expect_item({r, " read selector ack"}, 1); observe(ack);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      expect_item(r, ev[k]); observe(v);
    end
    expect_item("R8 line released after host nack", 0); observe(sda_oe);
    bus_stop;
    if (use_rs) begin end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int polls;
    rst_n = 0; scl = 1; sda_m = 1; wp = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    hp;

    // R10 reset state
    expect_item("R10 reset releases SDA", 0); observe(sda_oe);
    bus_start; send_byte(sel(11'd0, 1'b0), ack); bus_stop;
    expect_item("R10 selector acked right after reset", 1); observe(ack);

    // R2 wrong device code
    bus_start; send_byte(8'b1011_0000, ack); bus_stop;
    expect_item("R2 foreign code not acked", 0); observe(ack);

    // R4 write, R3 busy polling
    byte_write(11'h124, 8'hA5, "R4");
    bus_start; send_byte(sel(11'd0, 1'b0), ack); bus_stop;
    expect_item("R3 poll during busy nacked", 0); observe(ack);
    polls = 0;
    for (int i = 0; i < 40; i++) begin
      bus_start; send_byte(sel(11'd0, 1'b0), ack); bus_stop;
      polls++;
      if (ack) break;
    end
    expect_item("R3 poll acked after write cycle", 1); observe(ack);

    byte_write(11'h123, 8'h5A, "R4");
    wait_ready;

    // R6 current read after write to 0x123 gives 0x124
    read_seq(1, 8'hA5, 0, 0, "R6 current read after write", 1'b0);

    // R5 random read of 0x123
    set_pointer(11'h123);
    read_seq(1, 8'h5A, 0, 0, "R5 random read", 1'b1);
    // R6 current read after read of 0x123
    read_seq(1, 8'hA5, 0, 0, "R6 current read after read", 1'b0);

    // R7 wrap in sequential read
    byte_write(11'h7FF, 8'h11, "R7"); wait_ready;
    byte_write(11'h000, 8'h22, "R7"); wait_ready;
    byte_write(11'h001, 8'h33, "R7"); wait_ready;
    set_pointer(11'h7FF);
    read_seq(3, 8'h11, 8'h22, 8'h33, "R7 sequential read across wrap", 1'b1);

    // R8 MSB-first pattern
    byte_write(11'h2C0, 8'h81, "R8"); wait_ready;
    set_pointer(11'h2C0);
    read_seq(1, 8'h81, 0, 0, "R8 msb first", 1'b1);

    // R9 write protect
    byte_write(11'h010, 8'h44, "R9"); wait_ready;
    wp = 1;
    bus_start;
    expect_item("R9 selector acked under protect", 1); send_byte(sel(11'h010, 1'b0), ack); observe(ack);
    expect_item("R9 address acked under protect", 1);  send_byte(8'h10, ack); observe(ack);
    expect_item("R9 data nacked under protect", 0);    send_byte(8'h77, ack); observe(ack);
    bus_stop;
    bus_start; send_byte(sel(11'd0, 1'b0), ack); bus_stop;
    expect_item("R9 no busy after refused data", 1); observe(ack);
    wp = 0;
    set_pointer(11'h010);
    read_seq(1, 8'h44, 0, 0, "R9 protected byte unchanged", 1'b1);

    // R1 bus idle after STOP: slave releases
    expect_item("R1 SDA released on idle bus", 0); observe(sda_oe);

    wait (act_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule